// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block serializes pairs of 24-bit two's complement samples onto one data pin. A frame is 64 bit-clock periods long: the first half carries one channel and the second half the other. Each channel word is sent MSB first in the first 24 slots of its 32-slot half, and the last 8 slots are zero. The block runs from a fast system clock. In master mode it generates the bit clock and the frame clock itself. In slave mode it takes both clocks as inputs, passes them through a synchronizer and follows their edges.

Two frame layouts are supported. In the left-justified layout the MSB sits in the first slot after a frame-clock edge and the frame clock is high for the left channel. In the I2S layout the MSB comes one slot later and the frame clock is low for the left channel. The layout is selected by the level of an external pull resistor on the data pin. The block reads that level while reset is asserted, before it turns the pin into an output, and keeps the choice until the next reset.

Samples enter through a valid/ready handshake that holds one pair. The block moves that pair into the serializer when a left half begins. If no new pair is waiting, it sends the previous pair again. The serializer is controlled by a state machine with three states: ST_ALIGN, ST_LEFT and ST_RIGHT. After reset it starts in ST_ALIGN. It goes from ST_ALIGN to ST_LEFT at the first frame-clock edge into the left level that follows at least one earlier bit-clock fall. After that it moves from ST_LEFT to ST_RIGHT, and from ST_RIGHT back to ST_LEFT, at every frame-clock edge.

Top module: `sat_tx`

## Requirements
- R1: The level on `sdout_i` while `rst_n` is low selects the layout: 1 selects I2S, 0 selects left-justified. The choice is held until the next reset, whatever the pin does later.
- R2: While `rst_n` is low, `sdout_oe`, `sclk_oe` and `lrck_oe` are 0. After reset is released, `sdout_oe` is 1, and `sclk_oe` and `lrck_oe` equal `master_sel`.
- R3: When `master_sel` is 1, `sclk_o` has a period of 2*HALF_DIV system clocks. `lrck_o` changes only together with a falling edge of `sclk_o`, and each half-frame lasts 32 `sclk_o` periods.
- R4: When `master_sel` is 0, the block follows `sclk_i` and `lrck_i`. The half-frame boundaries are the edges of `lrck_i`, which the driver places on falling edges of `sclk_i`.
- R5: Each half-frame carries one 24-bit word, MSB first. The left word and then the right word of the same accepted pair form one frame.
- R6: In the left-justified layout, the MSB is in slot 0, the first slot after a frame-clock edge, and the left half is the one with the frame clock at 1.
- R7: In the I2S layout, slot 0 is 0, the MSB is in slot 1, and the left half is the one with the frame clock at 0.
- R8: Every slot of a half-frame that carries no data bit is driven 0: slots 24 to 31 in left-justified, and slots 0 and 25 to 31 in I2S.
- R9: `sdout_o` changes only in the system cycle after a bit-clock falling edge has been seen. It is therefore stable across each rising edge.
- R10: `in_ready` is 1 exactly when the one-pair holding slot is empty. After a transfer, `in_ready` is 0 in the next cycle. The held pair moves to the serializer when a left half begins.
- R11: If no new pair has been accepted, the previous pair is sent again. Accepted pairs appear in order, and none is skipped.
- R12: From reset release until alignment, and for every pair sent before the first accepted one, the data line is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset; the layout strap is read while it is low |
| master_sel | input | 1 | 1: generate bit and frame clocks; 0: follow the clock inputs |
| in_valid | input | 1 | A sample pair is offered |
| in_ready | output | 1 | The holding slot is empty and a pair can be taken |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| sclk_i | input | 1 | Bit clock from outside (slave mode) |
| lrck_i | input | 1 | Frame clock from outside (slave mode) |
| sclk_o | output | 1 | Generated bit clock (master mode) |
| lrck_o | output | 1 | Generated frame clock (master mode) |
| sclk_oe | output | 1 | Output enable for the bit clock pin |
| lrck_oe | output | 1 | Output enable for the frame clock pin |
| sdout_i | input | 1 | Level read back from the data pin (strap sense) |
| sdout_o | output | 1 | Serial data |
| sdout_oe | output | 1 | Output enable for the data pin |

## Verification
A wrong slot counter or a wrong layout offset moves every word by one bit. It also puts ones into slots that must be zero. The bench sees this in the first half-frame it decodes, about 32 bit clocks after alignment. A wrong hand-off between the holding slot and the serializer appears within two frames as a pair that is skipped, duplicated out of order, or split across frames. A wrong frame-clock polarity swaps left and right, so the first decoded pair after any accepted input fails. Fault in the master clock divider changes the measured bit period on the very next rising edge.

// File: rtl/sat_pkg.sv
`timescale 1ns/1ps
package sat_pkg;
    typedef enum logic {
        FMT_LJ  = 1'b0,
        FMT_I2S = 1'b1
    } fmt_e;

    typedef enum logic [1:0] {
        ST_ALIGN = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } tx_state_e;
endpackage

// File: rtl/sat_clkgen.sv
`timescale 1ns/1ps
// Bit/frame clock source: own divider in master mode, synchronized inputs in slave mode.
module sat_clkgen #(
    parameter int HALF_DIV    = 4,
    parameter int SLOTS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master_sel,
    input  logic left_lvl,
    input  logic sclk_i,
    input  logic lrck_i,
    output logic sclk_o,
    output logic lrck_o,
    output logic fall_evt,
    output logic lrck_at_fall
);
    localparam int DIV_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int FRAME_W = $clog2(2 * SLOTS);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    logic [DIV_W-1:0]   div_cnt;
    logic [FRAME_W-1:0] m_cnt;
    logic [FRAME_W-1:0] m_cnt_inc;
    logic               tick;
    logic               m_fall;
    logic               m_lrck_nxt;
    logic [SYNC_STAGES:0]   sc_pipe;
    logic [SYNC_STAGES-1:0] lr_pipe;
    logic               s_fall;

    assign tick       = (div_cnt == DIV_LAST);
    assign m_fall     = tick & sclk_o;
    assign m_cnt_inc  = m_cnt + 1'b1;
    assign m_lrck_nxt = m_cnt_inc[FRAME_W-1] ? ~left_lvl : left_lvl;

    // Master generator: sclk starts high so its first toggle is a falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            sclk_o  <= 1'b1;
            m_cnt   <= '1;
            lrck_o  <= ~left_lvl;
        end else begin
            div_cnt <= tick ? '0 : div_cnt + 1'b1;
            if (tick) begin
                sclk_o <= ~sclk_o;
            end
            if (m_fall) begin
                m_cnt  <= m_cnt_inc;
                lrck_o <= m_lrck_nxt;
            end
        end
    end

    // Slave path: both clocks pass through equal-depth synchronizers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_pipe <= '1;
            lr_pipe <= '0;
        end else begin
            sc_pipe <= {sc_pipe[SYNC_STAGES-1:0], sclk_i};
            lr_pipe <= {lr_pipe[SYNC_STAGES-2:0], lrck_i};
        end
    end

    assign s_fall = sc_pipe[SYNC_STAGES] & ~sc_pipe[SYNC_STAGES-1];

    assign fall_evt     = master_sel ? m_fall : s_fall;
    assign lrck_at_fall = master_sel ? m_lrck_nxt : lr_pipe[SYNC_STAGES-1];
endmodule

// File: rtl/sat_frame_fsm.sv
`timescale 1ns/1ps
// Layout strap latch, half-frame state machine and slot counter.
module sat_frame_fsm
    import sat_pkg::*;
#(
    parameter int SLOTS = 32,
    localparam int SI   = $clog2(SLOTS)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strap_lvl,
    input  logic      fall_evt,
    input  logic      lrck_at_fall,
    output fmt_e      fmt,
    output logic      left_lvl,
    output tx_state_e state_nxt,
    output logic [SI-1:0] slot_nxt,
    output logic      load
);
    localparam logic [SI-1:0] SLOT_LAST = SI'(SLOTS - 1);

    tx_state_e     state;
    logic          primed;
    logic          lrck_prev;
    logic [SI-1:0] slot;
    logic          edge_seen;
    logic          into_left;

    // Strap sensed every cycle of reset, frozen afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt <= strap_lvl ? FMT_I2S : FMT_LJ;
        end
    end

    assign left_lvl  = (fmt == FMT_LJ);
    assign edge_seen = fall_evt && primed && (lrck_at_fall != lrck_prev);
    assign into_left = edge_seen && (lrck_at_fall == left_lvl);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_ALIGN;
        end else begin
            state <= state_nxt;
        end
    end

    // Next state and outputs.
    always_comb begin
        state_nxt = state;
        load      = 1'b0;
        unique case (state)
            ST_ALIGN: begin
                if (into_left) begin
                    state_nxt = ST_LEFT;
                    load      = 1'b1;
                end
            end
            ST_LEFT: begin
                if (edge_seen) begin
                    state_nxt = ST_RIGHT;
                end
            end
            ST_RIGHT: begin
                if (edge_seen) begin
                    state_nxt = ST_LEFT;
                    load      = 1'b1;
                end
            end
            default: begin
                state_nxt = ST_ALIGN;
            end
        endcase
    end

    always_comb begin
        if (!fall_evt) begin
            slot_nxt = slot;
        end else if (edge_seen) begin
            slot_nxt = '0;
        end else if (slot == SLOT_LAST) begin
            slot_nxt = slot;
        end else begin
            slot_nxt = slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed    <= 1'b0;
            lrck_prev <= 1'b0;
            slot      <= SLOT_LAST;
        end else begin
            primed <= primed | fall_evt;
            slot   <= slot_nxt;
            if (fall_evt) begin
                lrck_prev <= lrck_at_fall;
            end
        end
    end
endmodule

// File: rtl/sat_pair_buf.sv
`timescale 1ns/1ps
// One-pair holding slot in front of the active pair used by the serializer.
module sat_pair_buf #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_left,
    input  logic [WORD_W-1:0] in_right,
    input  logic              load,
    output logic [WORD_W-1:0] word_l,
    output logic [WORD_W-1:0] word_r
);
    logic              pend_full;
    logic [WORD_W-1:0] pend_l;
    logic [WORD_W-1:0] pend_r;
    logic [WORD_W-1:0] act_l;
    logic [WORD_W-1:0] act_r;
    logic              accept;

    assign in_ready = ~pend_full;
    assign accept   = in_valid & ~pend_full;
    // Left word is needed in the load cycle itself, so bypass the held pair.
    assign word_l   = (load && pend_full) ? pend_l : act_l;
    assign word_r   = act_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_full <= 1'b0;
            pend_l    <= '0;
            pend_r    <= '0;
            act_l     <= '0;
            act_r     <= '0;
        end else begin
            if (load && pend_full) begin
                act_l     <= pend_l;
                act_r     <= pend_r;
                pend_full <= 1'b0;
            end
            if (accept) begin
                pend_l    <= in_left;
                pend_r    <= in_right;
                pend_full <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sat_shifter.sv
`timescale 1ns/1ps
// Picks the bit for the coming slot and registers it on a bit-clock fall.
module sat_shifter
    import sat_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int SLOTS  = 32,
    localparam int SI    = $clog2(SLOTS),
    localparam int WI    = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_e              fmt,
    input  logic              fall_evt,
    input  tx_state_e         state_nxt,
    input  logic [SI-1:0]     slot_nxt,
    input  logic [WORD_W-1:0] word_l,
    input  logic [WORD_W-1:0] word_r,
    output logic              sdout_q
);
    logic [WORD_W-1:0] sel_word;
    logic [WORD_W-1:0] rev;
    logic [SI:0]       slot_x;
    logic [SI:0]       off_x;
    logic [SI:0]       rel;
    logic              in_rng;
    logic              tx_bit;

    assign sel_word = (state_nxt == ST_LEFT) ? word_l : word_r;

    // Bit-reversed copy so slot order indexes directly.
    for (genvar g = 0; g < WORD_W; g++) begin : g_rev
        assign rev[g] = sel_word[WORD_W-1-g];
    end

    assign slot_x = {1'b0, slot_nxt};
    assign off_x  = (fmt == FMT_I2S) ? (SI+1)'(1) : '0;
    assign rel    = slot_x - off_x;
    assign in_rng = (slot_x >= off_x) && (rel < (SI+1)'(WORD_W));
    assign tx_bit = (state_nxt != ST_ALIGN) && in_rng && rev[rel[WI-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdout_q <= 1'b0;
        end else if (fall_evt) begin
            sdout_q <= tx_bit;
        end
    end
endmodule

// File: rtl/sat_tx.sv
`timescale 1ns/1ps
module sat_tx
    import sat_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int SLOTS       = 32,
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_sel,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_left,
    input  logic [WORD_W-1:0] in_right,
    input  logic              sclk_i,
    input  logic              lrck_i,
    output logic              sclk_o,
    output logic              lrck_o,
    output logic              sclk_oe,
    output logic              lrck_oe,
    input  logic              sdout_i,
    output logic              sdout_o,
    output logic              sdout_oe
);
    localparam int SI = $clog2(SLOTS);

    fmt_e              fmt;
    logic              left_lvl;
    logic              fall_evt;
    logic              lrck_at_fall;
    tx_state_e         state_nxt;
    logic [SI-1:0]     slot_nxt;
    logic              load;
    logic [WORD_W-1:0] word_l;
    logic [WORD_W-1:0] word_r;

    assign sdout_oe = rst_n;
    assign sclk_oe  = rst_n & master_sel;
    assign lrck_oe  = rst_n & master_sel;

    sat_clkgen #(
        .HALF_DIV   (HALF_DIV),
        .SLOTS      (SLOTS),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_clk (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_sel  (master_sel),
        .left_lvl    (left_lvl),
        .sclk_i      (sclk_i),
        .lrck_i      (lrck_i),
        .sclk_o      (sclk_o),
        .lrck_o      (lrck_o),
        .fall_evt    (fall_evt),
        .lrck_at_fall(lrck_at_fall)
    );

    sat_frame_fsm #(
        .SLOTS(SLOTS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_lvl   (sdout_i),
        .fall_evt    (fall_evt),
        .lrck_at_fall(lrck_at_fall),
        .fmt         (fmt),
        .left_lvl    (left_lvl),
        .state_nxt   (state_nxt),
        .slot_nxt    (slot_nxt),
        .load        (load)
    );

    sat_pair_buf #(
        .WORD_W(WORD_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_ready(in_ready),
        .in_left (in_left),
        .in_right(in_right),
        .load    (load),
        .word_l  (word_l),
        .word_r  (word_r)
    );

    sat_shifter #(
        .WORD_W(WORD_W),
        .SLOTS (SLOTS)
    ) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt      (fmt),
        .fall_evt (fall_evt),
        .state_nxt(state_nxt),
        .slot_nxt (slot_nxt),
        .word_l   (word_l),
        .word_r   (word_r),
        .sdout_q  (sdout_o)
    );
endmodule

// File: rtl/sat_tx_chk.sv
`timescale 1ns/1ps
module sat_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic master_sel,
    input logic in_valid,
    input logic in_ready,
    input logic sclk_o,
    input logic lrck_o,
    input logic sclk_oe,
    input logic lrck_oe,
    input logic sdout_o,
    input logic sdout_oe,
    input logic fall_evt,
    input logic fmt
);
    a_r2_oe_low_in_reset: assert property (@(posedge clk)
        !rst_n |-> (!sdout_oe && !sclk_oe && !lrck_oe));

    a_r1_fmt_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(fmt));

    a_r9_data_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_evt |=> $stable(sdout_o));

    a_r10_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    a_r3_lrck_with_sclk_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && (lrck_o != $past(lrck_o))) |-> $fell(sclk_o));
endmodule

bind sat_tx sat_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .master_sel(master_sel),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .sclk_o    (sclk_o),
    .lrck_o    (lrck_o),
    .sclk_oe   (sclk_oe),
    .lrck_oe   (lrck_oe),
    .sdout_o   (sdout_o),
    .sdout_oe  (sdout_oe),
    .fall_evt  (fall_evt),
    .fmt       (fmt)
);

// File: tb/sat_tx_tb.sv
`timescale 1ns/1ps
module sat_tx_tb;
    localparam int W       = 24;
    localparam int HALF    = 4;
    localparam int SL_HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_sel = 1'b0;
    logic in_valid = 1'b0;
    logic [W-1:0] in_l = '0;
    logic [W-1:0] in_r = '0;
    logic sclk_i = 1'b1;
    logic lrck_i = 1'b0;
    logic strap = 1'b0;
    logic in_ready, sclk_o, lrck_o, sclk_oe, lrck_oe, sdout_o, sdout_oe;
    logic sdout_i;
    logic sclk_w, lrck_w;

    assign sdout_i = sdout_oe ? sdout_o : strap;   // pin with pull resistor
    assign sclk_w  = master_sel ? sclk_o : sclk_i;
    assign lrck_w  = master_sel ? lrck_o : lrck_i;

    sat_tx #(.WORD_W(W), .HALF_DIV(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_left(in_l), .in_right(in_r),
        .sclk_i(sclk_i), .lrck_i(lrck_i), .sclk_o(sclk_o), .lrck_o(lrck_o),
        .sclk_oe(sclk_oe), .lrck_oe(lrck_oe),
        .sdout_i(sdout_i), .sdout_o(sdout_o), .sdout_oe(sdout_oe)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit slave_on = 0, run = 0, armed = 0, fmt_i2s = 0;
    logic [W-1:0] acc_l [0:15];
    logic [W-1:0] acc_r [0:15];
    int n_acc = 0, ptr = -1, repeats = 0;
    int halves = 0, cnt = 0;
    bit hv = 0, plv = 0, have_l = 0;
    logic [W-1:0] cur_l;
    logic [0:63] bits;
    longint last_rise = -1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] take_word(input logic [0:63] b, input int off);
        logic [W-1:0] w = '0;
        for (int s = 0; s < W; s++) w = {w[W-2:0], b[s+off]};
        return w;
    endfunction

    function automatic bit zeros_ok(input logic [0:63] b, input int off);
        for (int s = 0; s < 32; s++)
            if ((s < off || s >= off + W) && b[s]) return 0;
        return 1;
    endfunction

    task automatic pair_check(input logic [W-1:0] l, input logic [W-1:0] r);
        bit ok;
        longint expv;
        ok = 0;
        expv = 0;
        if (ptr >= 0) expv = {acc_l[ptr], acc_r[ptr]};
        if (ptr + 1 < n_acc && l == acc_l[ptr+1] && r == acc_r[ptr+1]) begin
            ptr++; ok = 1;
        end else if (ptr >= 0 && l == acc_l[ptr] && r == acc_r[ptr]) begin
            ok = 1; repeats++;
        end else if (ptr < 0 && l == '0 && r == '0) begin
            ok = 1;   // R12: nothing accepted yet, line stays zero
        end
        if (!ok && ptr + 1 < n_acc) expv = {acc_l[ptr+1], acc_r[ptr+1]};
        chk(ok, fmt_i2s ? "R5 R7 R11 pair" : "R5 R6 R11 pair", {l, r}, expv);
    endtask

    task automatic do_half(input bit lv, input int n);
        int off;
        logic [W-1:0] w;
        bit left_lvl;
        halves++;
        if (halves >= 4) armed = 1;
        if (halves <= 1) return;
        chk(n == 32, master_sel ? "R3 half length" : "R4 half length", n, 32);
        off = fmt_i2s ? 1 : 0;
        chk(zeros_ok(bits, off), "R8 unused slots", 1, 0);
        w = take_word(bits, off);
        left_lvl = fmt_i2s ? 1'b0 : 1'b1;
        if (lv == left_lvl) begin
            cur_l = w; have_l = 1;
        end else if (have_l) begin
            have_l = 0;
            pair_check(cur_l, w);
        end
    endtask

    // Slave-mode clock source: lrck moves with sclk falls, 32 bits per half.
    initial begin
        int c = 0;
        int bc = 0;
        forever begin
            @(negedge clk);
            if (!slave_on) begin
                sclk_i = 1'b1; lrck_i = fmt_i2s; c = 0; bc = 0;
            end else begin
                c++;
                if (c == SL_HALF) begin
                    c = 0;
                    if (sclk_i) begin
                        sclk_i = 1'b0; bc++;
                        if (bc == 32) begin bc = 0; lrck_i = ~lrck_i; end
                    end else begin
                        sclk_i = 1'b1;
                    end
                end
            end
        end
    end

    // Monitor: sample on each bit-clock rise.
    initial begin
        forever begin
            @(posedge sclk_w);
            #1;
            if (run) begin
                bit b, lv;
                longint t;
                b = sdout_o; lv = lrck_w; t = $time;
                if (master_sel && last_rise >= 0)
                    chk((t - last_rise) == 2 * HALF * 10, "R3 sclk period", t - last_rise, 2 * HALF * 10);
                last_rise = t;
                if (hv && lv != plv) begin
                    do_half(plv, cnt);
                    cnt = 0; bits = '0;
                end
                if (cnt < 64) bits[cnt] = b;
                cnt++; plv = lv; hv = 1;
                #15;
                chk(sdout_o == b, "R9 stable around rise", sdout_o, b);
            end
        end
    end

    task automatic run_phase(input bit m, input bit i2s);
        run = 0; slave_on = 0; rst_n = 0; in_valid = 0;
        master_sel = m; fmt_i2s = i2s; strap = i2s;
        n_acc = 0; ptr = -1; repeats = 0;
        halves = 0; cnt = 0; hv = 0; have_l = 0; armed = 0; bits = '0; last_rise = -1;
        repeat (6) @(negedge clk);
        chk({sdout_oe, sclk_oe, lrck_oe} == 3'b000, "R2 oe in reset", {sdout_oe, sclk_oe, lrck_oe}, 0);
        rst_n = 1; slave_on = !m; run = 1;
        @(negedge clk);
        chk(sdout_oe && sclk_oe == m && lrck_oe == m, "R2 oe after reset",
            {sdout_oe, sclk_oe, lrck_oe}, {1'b1, m, m});
        strap = ~i2s;   // R1: later pin level must not change the layout
        repeat (40) @(negedge clk);
        chk(sdout_o == 1'b0, "R12 idle line", sdout_o, 0);
        wait (armed);
        @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            int gap;
            gap = $urandom_range(0, 900);
            repeat (gap) @(negedge clk);
            if (k == 0) begin in_l = 24'h800000; in_r = 24'h7FFFFF; end
            else if (k == 1) begin in_l = 24'hFFFFFF; in_r = 24'h000001; end
            else begin in_l = W'($urandom); in_r = W'($urandom); end
            while (!in_ready) @(negedge clk);
            in_valid = 1;
            @(negedge clk);
            in_valid = 0;
            acc_l[n_acc] = in_l; acc_r[n_acc] = in_r; n_acc++;
            chk(in_ready == 1'b0, "R10 slot full", in_ready, 0);
        end
        repeat (3500) @(negedge clk);
        chk(ptr == n_acc - 1, "R11 all pairs sent in order", ptr, n_acc - 1);
        chk(repeats > 0, "R11 repeat when idle", repeats, 1);
        chk(in_ready == 1'b1, "R10 slot drained", in_ready, 1);
        run = 0; slave_on = 0;
        repeat (20) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5A17));
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        run_phase(1'b0, 1'b0);   // slave, left-justified
        run_phase(1'b0, 1'b1);   // slave, I2S
        run_phase(1'b1, 1'b0);   // master, left-justified
        run_phase(1'b1, 1'b1);   // master, I2S
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule